// File: doc/BRIEF.md
# GO-staged clock divider bank

This block turns one reference clock into a set of divided clock enables. Each output has its own divide ratio and enable. A post-divider can sit in front of the whole bank, or a bypass can skip it. Software reaches the block through a plain single-cycle register bus. Writes to the ratio and enable fields land in shadow copies. The live dividers only take the new values when software writes the GO command.

A GO copies every shadow into the active set at once and restarts every counter, including the post-divider, on the same reference edge. Because of this, the outputs come out phase-aligned after each change. A busy status bit stays set for a fixed number of cycles after the GO, and a second GO in that window is dropped. The multiplier register drives an output for an external multiplied-clock model. It is written directly and bypasses the staging. The bypass select in the control register also acts at once.

Register map (4-bit word address, 16-bit data): 0x0 control, where bit 0 = 1 selects bypass. 0x1 multiplier. 0x2 post-divider. 0x3 command, write-only, reads 0. 0x4 status, read-only. 0x8 + i is divider i. Addresses not listed read 0.

Top module: `clkdiv_bank`

## Requirements
- R1: After reset, control reads 0x0001 and multiplier reads 0. The post-divider and every divider read 0x8000, status reads 0, and every clock enable is high on every cycle.
- R2: In the divider and post-divider registers, bit 15 is the enable and bits RATIO_W-1:0 hold the ratio field. The divide factor is field + 1, so field 0 gives an enable on every source tick.
- R3: While a divider's active enable bit is 0, its clock enable output stays low.
- R4: A write to a divider or the post-divider changes only its shadow copy. Read-back shows the new value at once, and the outputs keep their old pattern until a GO is accepted.
- R5: Writing 1 to command bit 0 while not busy loads all shadows into the active set and restarts every counter. In cycle c after the GO edge (c = 0 first), output i is high when (c+1) is a multiple of F_i·P. P is the post factor, or 1 in bypass.
- R6: Status bit 0, and the `xfer_busy` output, read 1 for exactly BUSY_CYCLES cycles starting in the cycle after an accepted GO, and then read 0.
- R7: A GO written while busy has no effect. The active ratios stay the same, the counters keep running, and any staged values stay pending.
- R8: A write to the multiplier register appears on `mult_val` in the next cycle, with no GO needed.
- R9: Control bit 0 acts at once. When it is 1, the dividers tick on every reference cycle. When it is 0, they tick on the post-divider's output.
- R10: Outside bypass, a post-divider whose active enable is 0 holds every clock enable output low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| mult_val | output | MULT_W | Multiplier value for the external multiplied-clock model |
| xfer_busy | output | 1 | Transition in progress (status bit 0) |
| div_clk_en | output | NUM_DIV | One divided clock enable per divider |

## Verification
- **Clock enables and busy:** both are decoded from registers, so the first cycle that follows the GO edge already shows cycle 0 of the new pattern and a set busy bit.
- **Multiplier:** the value shows one cycle after its write edge.
- **Read data:** it follows the address within the same cycle.
- **How the checks keep to this:** after every clock edge, the bench works out the prediction for the cycle now starting, based on its own count of cycles since the last accepted GO. That prediction is compared at the next falling edge.
- **Bypass switch:** in the one cycle where a bypass change meets a post-divider in mid-count, the bench records no prediction.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int REG_W  = 16;
  localparam int ADDR_W = 4;
  localparam int EN_BIT = 15;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL = 4'h0,
    A_MULT = 4'h1,
    A_POST = 4'h2,
    A_CMD  = 4'h3,
    A_STAT = 4'h4
  } reg_addr_e;

  localparam logic [ADDR_W-1:0] A_DIV_BASE = 4'h8;
endpackage

// File: rtl/clkdiv_rst_sync.sv
module clkdiv_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/clkdiv_counter.sv
module clkdiv_counter #(
  parameter int RATIO_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               restart,
  input  logic               tick,
  input  logic               en,
  input  logic [RATIO_W-1:0] ratio,
  output logic               pulse
);
  logic [RATIO_W-1:0] cnt_q, cnt_d;
  logic               hit;

  assign hit = (cnt_q >= ratio);

  always_comb begin
    cnt_d = cnt_q;
    if (restart)   cnt_d = '0;
    else if (tick) cnt_d = hit ? '0 : cnt_q + RATIO_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign pulse = tick & en & hit;
endmodule

// File: rtl/clkdiv_regs.sv
module clkdiv_regs import clkdiv_pkg::*; #(
  parameter int NUM_DIV     = 4,
  parameter int RATIO_W     = 5,
  parameter int MULT_W      = 5,
  parameter int BUSY_CYCLES = 8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            bus_wr,
  input  logic [ADDR_W-1:0]               bus_addr,
  input  logic [REG_W-1:0]                bus_wdata,
  output logic [REG_W-1:0]                bus_rdata,
  output logic [MULT_W-1:0]               mult_val,
  output logic                            bypass,
  output logic                            post_en,
  output logic [RATIO_W-1:0]              post_ratio,
  output logic [NUM_DIV-1:0]              act_en,
  output logic [NUM_DIV-1:0][RATIO_W-1:0] act_ratio,
  output logic                            go_pulse,
  output logic                            busy
);
  localparam int BCNT_W = (BUSY_CYCLES > 1) ? $clog2(BUSY_CYCLES) : 1;
  localparam logic [BCNT_W-1:0] BCNT_LOAD = BCNT_W'(BUSY_CYCLES - 1);

  logic                            byp_q, byp_d;
  logic [MULT_W-1:0]               mult_q, mult_d;
  logic                            shp_en_q, shp_en_d;
  logic [RATIO_W-1:0]              shp_r_q, shp_r_d;
  logic                            acp_en_q, acp_en_d;
  logic [RATIO_W-1:0]              acp_r_q, acp_r_d;
  logic [NUM_DIV-1:0]              sh_en_q, sh_en_d;
  logic [NUM_DIV-1:0][RATIO_W-1:0] sh_r_q, sh_r_d;
  logic [NUM_DIV-1:0]              ac_en_q, ac_en_d;
  logic [NUM_DIV-1:0][RATIO_W-1:0] ac_r_q, ac_r_d;
  logic                            busy_q, busy_d;
  logic [BCNT_W-1:0]               bcnt_q, bcnt_d;

  logic               wr_ctrl, wr_mult, wr_post, go_acc;
  logic [NUM_DIV-1:0] wr_div;
  logic               unused_wdata;

  assign unused_wdata = ^bus_wdata;

  assign wr_ctrl = bus_wr && (bus_addr == A_CTRL);
  assign wr_mult = bus_wr && (bus_addr == A_MULT);
  assign wr_post = bus_wr && (bus_addr == A_POST);
  assign go_acc  = bus_wr && (bus_addr == A_CMD) && bus_wdata[0] && !busy_q;

  for (genvar g = 0; g < NUM_DIV; g++) begin : g_dec
    assign wr_div[g] = bus_wr && (bus_addr == (A_DIV_BASE + ADDR_W'(g)));
  end

  // next-state
  always_comb begin
    byp_d    = wr_ctrl ? bus_wdata[0] : byp_q;
    mult_d   = wr_mult ? bus_wdata[MULT_W-1:0] : mult_q;
    shp_en_d = wr_post ? bus_wdata[EN_BIT] : shp_en_q;
    shp_r_d  = wr_post ? bus_wdata[RATIO_W-1:0] : shp_r_q;
    for (int i = 0; i < NUM_DIV; i++) begin
      sh_en_d[i] = wr_div[i] ? bus_wdata[EN_BIT] : sh_en_q[i];
      sh_r_d[i]  = wr_div[i] ? bus_wdata[RATIO_W-1:0] : sh_r_q[i];
    end
    // staged values move to the live set only on an accepted GO
    acp_en_d = go_acc ? shp_en_q : acp_en_q;
    acp_r_d  = go_acc ? shp_r_q  : acp_r_q;
    ac_en_d  = go_acc ? sh_en_q  : ac_en_q;
    ac_r_d   = go_acc ? sh_r_q   : ac_r_q;

    busy_d = busy_q;
    bcnt_d = bcnt_q;
    if (go_acc) begin
      busy_d = 1'b1;
      bcnt_d = BCNT_LOAD;
    end else if (busy_q) begin
      if (bcnt_q == '0) busy_d = 1'b0;
      else              bcnt_d = bcnt_q - BCNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byp_q    <= 1'b1;
      mult_q   <= '0;
      shp_en_q <= 1'b1;
      shp_r_q  <= '0;
      acp_en_q <= 1'b1;
      acp_r_q  <= '0;
      sh_en_q  <= '1;
      sh_r_q   <= '0;
      ac_en_q  <= '1;
      ac_r_q   <= '0;
      busy_q   <= 1'b0;
      bcnt_q   <= '0;
    end else begin
      byp_q    <= byp_d;
      mult_q   <= mult_d;
      shp_en_q <= shp_en_d;
      shp_r_q  <= shp_r_d;
      acp_en_q <= acp_en_d;
      acp_r_q  <= acp_r_d;
      sh_en_q  <= sh_en_d;
      sh_r_q   <= sh_r_d;
      ac_en_q  <= ac_en_d;
      ac_r_q   <= ac_r_d;
      busy_q   <= busy_d;
      bcnt_q   <= bcnt_d;
    end
  end

  // read mux: shadows are what software sees
  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL: bus_rdata[0] = byp_q;
      A_MULT: bus_rdata[MULT_W-1:0] = mult_q;
      A_POST: begin
        bus_rdata[EN_BIT]        = shp_en_q;
        bus_rdata[RATIO_W-1:0]   = shp_r_q;
      end
      A_STAT: bus_rdata[0] = busy_q;
      default: ;
    endcase
    for (int i = 0; i < NUM_DIV; i++) begin
      if (bus_addr == (A_DIV_BASE + ADDR_W'(i))) begin
        bus_rdata[EN_BIT]      = sh_en_q[i];
        bus_rdata[RATIO_W-1:0] = sh_r_q[i];
      end
    end
  end

  assign mult_val   = mult_q;
  assign bypass     = byp_q;
  assign post_en    = acp_en_q;
  assign post_ratio = acp_r_q;
  assign act_en     = ac_en_q;
  assign act_ratio  = ac_r_q;
  assign go_pulse   = go_acc;
  assign busy       = busy_q;
endmodule

// File: rtl/clkdiv_bank.sv
module clkdiv_bank import clkdiv_pkg::*; #(
  parameter int NUM_DIV     = 4,
  parameter int RATIO_W     = 5,
  parameter int MULT_W      = 5,
  parameter int BUSY_CYCLES = 8
) (
  input  logic               clk_ref,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [REG_W-1:0]   bus_wdata,
  output logic [REG_W-1:0]   bus_rdata,
  output logic [MULT_W-1:0]  mult_val,
  output logic               xfer_busy,
  output logic [NUM_DIV-1:0] div_clk_en
);
  logic                            rst_sync_n;
  logic                            bypass;
  logic                            post_en;
  logic [RATIO_W-1:0]              post_ratio;
  logic [NUM_DIV-1:0]              act_en;
  logic [NUM_DIV-1:0][RATIO_W-1:0] act_ratio;
  logic                            go_pulse;
  logic                            post_tick;
  logic                            src_tick;

  clkdiv_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk_ref),
    .arst_n     (rst_n),
    .rst_n_sync (rst_sync_n)
  );

  clkdiv_regs #(
    .NUM_DIV(NUM_DIV), .RATIO_W(RATIO_W), .MULT_W(MULT_W), .BUSY_CYCLES(BUSY_CYCLES)
  ) u_regs (
    .clk        (clk_ref),
    .rst_n      (rst_sync_n),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .mult_val   (mult_val),
    .bypass     (bypass),
    .post_en    (post_en),
    .post_ratio (post_ratio),
    .act_en     (act_en),
    .act_ratio  (act_ratio),
    .go_pulse   (go_pulse),
    .busy       (xfer_busy)
  );

  // post-divider runs on every reference cycle
  clkdiv_counter #(.RATIO_W(RATIO_W)) u_post (
    .clk     (clk_ref),
    .rst_n   (rst_sync_n),
    .restart (go_pulse),
    .tick    (1'b1),
    .en      (post_en),
    .ratio   (post_ratio),
    .pulse   (post_tick)
  );

  assign src_tick = bypass | post_tick;

  for (genvar g = 0; g < NUM_DIV; g++) begin : g_div
    clkdiv_counter #(.RATIO_W(RATIO_W)) u_cnt (
      .clk     (clk_ref),
      .rst_n   (rst_sync_n),
      .restart (go_pulse),
      .tick    (src_tick),
      .en      (act_en[g]),
      .ratio   (act_ratio[g]),
      .pulse   (div_clk_en[g])
    );
  end
endmodule

// File: rtl/clkdiv_bank_chk.sv
module clkdiv_bank_chk import clkdiv_pkg::*; #(
  parameter int NUM_DIV     = 4,
  parameter int RATIO_W     = 5,
  parameter int MULT_W      = 5,
  parameter int BUSY_CYCLES = 8
) (
  input logic                            clk_ref,
  input logic                            rst_sync_n,
  input logic                            bus_wr,
  input logic [ADDR_W-1:0]               bus_addr,
  input logic [REG_W-1:0]                bus_wdata,
  input logic [MULT_W-1:0]               mult_val,
  input logic                            xfer_busy,
  input logic [NUM_DIV-1:0]              div_clk_en,
  input logic                            bypass,
  input logic [NUM_DIV-1:0]              act_en,
  input logic [NUM_DIV-1:0][RATIO_W-1:0] act_ratio
);
  localparam int LEN_W = $clog2(BUSY_CYCLES + 1) + 1;

  logic             go_wr;
  logic [LEN_W-1:0] busy_len;

  assign go_wr = bus_wr && (bus_addr == A_CMD) && bus_wdata[0];

  always_ff @(posedge clk_ref or negedge rst_sync_n) begin
    if (!rst_sync_n)    busy_len <= '0;
    else if (xfer_busy) busy_len <= busy_len + LEN_W'(1);
    else                busy_len <= '0;
  end

  assert_go_sets_busy_R5: assert property (@(posedge clk_ref) disable iff (!rst_sync_n)
    (go_wr && !xfer_busy) |=> xfer_busy);

  assert_busy_len_R6: assert property (@(posedge clk_ref) disable iff (!rst_sync_n)
    $fell(xfer_busy) |-> (busy_len == LEN_W'(BUSY_CYCLES)));

  assert_busy_bound_R6: assert property (@(posedge clk_ref) disable iff (!rst_sync_n)
    xfer_busy |-> (busy_len < LEN_W'(BUSY_CYCLES)));

  assert_active_hold_R4: assert property (@(posedge clk_ref) disable iff (!rst_sync_n)
    !go_wr |=> ($stable(act_ratio) && $stable(act_en)));

  assert_go_ignored_R7: assert property (@(posedge clk_ref) disable iff (!rst_sync_n)
    (go_wr && xfer_busy) |=> ($stable(act_ratio) && $stable(act_en)));

  assert_mult_direct_R8: assert property (@(posedge clk_ref) disable iff (!rst_sync_n)
    (bus_wr && bus_addr == A_MULT) |=> (mult_val == $past(bus_wdata[MULT_W-1:0])));

  for (genvar g = 0; g < NUM_DIV; g++) begin : g_chk
    assert_div1_every_cycle_R2: assert property (@(posedge clk_ref) disable iff (!rst_sync_n)
      (bypass && act_en[g] && act_ratio[g] == '0) |-> div_clk_en[g]);

    assert_disabled_quiet_R3: assert property (@(posedge clk_ref) disable iff (!rst_sync_n)
      !act_en[g] |-> !div_clk_en[g]);
  end
endmodule

bind clkdiv_bank clkdiv_bank_chk #(
  .NUM_DIV(NUM_DIV), .RATIO_W(RATIO_W), .MULT_W(MULT_W), .BUSY_CYCLES(BUSY_CYCLES)
) u_chk (
  .clk_ref    (clk_ref),
  .rst_sync_n (rst_sync_n),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .mult_val   (mult_val),
  .xfer_busy  (xfer_busy),
  .div_clk_en (div_clk_en),
  .bypass     (bypass),
  .act_en     (act_en),
  .act_ratio  (act_ratio)
);

// File: tb/clkdiv_bank_bench.sv
module clkdiv_bank_bench;
  localparam int ND = 4;
  localparam int RW = 5;
  localparam int MW = 5;
  localparam int BC = 8;

  logic          clk_ref = 1'b0;
  logic          rst_n;
  logic          bus_wr;
  logic [3:0]    bus_addr;
  logic [15:0]   bus_wdata;
  logic [15:0]   bus_rdata;
  logic [MW-1:0] mult_val;
  logic          xfer_busy;
  logic [ND-1:0] div_clk_en;

  int checks = 0;
  int fails  = 0;

  always #5 clk_ref = ~clk_ref;

  clkdiv_bank #(.NUM_DIV(ND), .RATIO_W(RW), .MULT_W(MW), .BUSY_CYCLES(BC)) u_clkdiv_bank (
    .clk_ref(clk_ref), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mult_val(mult_val),
    .xfer_busy(xfer_busy), .div_clk_en(div_clk_en)
  );

  // reference model state
  bit m_byp;
  bit shp_en, acp_en;
  int shp_r, acp_r;
  bit sh_en[ND];
  bit ac_en[ND];
  int sh_r[ND];
  int ac_r[ND];
  int bleft, phase;
  bit skip;
  string cur_tag;
  bit pend_wr;
  int pend_addr, pend_data;

  // scoreboard queues
  logic [ND-1:0] q_en[$];
  logic          q_busy[$];
  string         q_tag[$];

  function automatic logic [ND-1:0] exp_en(int c);
    logic [ND-1:0] v;
    int p;
    bit ok;
    p  = m_byp ? 1 : acp_r + 1;
    ok = m_byp || acp_en;
    for (int i = 0; i < ND; i++)
      v[i] = ac_en[i] && ok && (((c + 1) % ((ac_r[i] + 1) * p)) == 0);
    return v;
  endfunction

  task automatic cycle();
    bit go;
    @(posedge clk_ref);
    go = pend_wr && pend_addr == 3 && pend_data[0] && bleft == 0;
    if (go) bleft = BC;
    else if (bleft > 0) bleft--;
    if (pend_wr) begin
      if (pend_addr == 0) m_byp = pend_data[0];
      if (pend_addr == 2) begin shp_en = pend_data[15]; shp_r = pend_data[RW-1:0]; end
      for (int i = 0; i < ND; i++)
        if (pend_addr == 8 + i) begin sh_en[i] = pend_data[15]; sh_r[i] = pend_data[RW-1:0]; end
    end
    if (go) begin
      acp_en = shp_en; acp_r = shp_r;
      for (int i = 0; i < ND; i++) begin ac_en[i] = sh_en[i]; ac_r[i] = sh_r[i]; end
      phase = 0;
    end
    #1;
    bus_wr  = 1'b0;
    pend_wr = 1'b0;
    if (!skip) begin
      q_en.push_back(exp_en(phase));
      q_busy.push_back(bleft > 0);
      q_tag.push_back(cur_tag);
    end
    phase++;
  endtask

  task automatic wr(int a, int d);
    bus_wr = 1'b1; bus_addr = 4'(a); bus_wdata = 16'(d);
    pend_wr = 1'b1; pend_addr = a; pend_data = d;
    cycle();
  endtask

  task automatic idle(int n);
    repeat (n) cycle();
  endtask

  task automatic check_rd(int a, int expv, string tag);
    bus_addr = 4'(a);
    #1;
    checks++;
    if (bus_rdata !== 16'(expv)) begin
      fails++;
      $display("FAIL %s read addr %0h: actual=%h expected=%h", tag, a, bus_rdata, 16'(expv));
    end
  endtask

  // monitor
  always @(negedge clk_ref) begin
    if (q_en.size() > 0) begin
      logic [ND-1:0] e;
      logic          b;
      string         t;
      e = q_en.pop_front();
      b = q_busy.pop_front();
      t = q_tag.pop_front();
      checks++;
      if (div_clk_en !== e || xfer_busy !== b) begin
        fails++;
        $display("FAIL %s phase: actual en=%b busy=%b expected en=%b busy=%b",
                 t, div_clk_en, xfer_busy, e, b);
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk_ref);
    fails++;
    $display("FAIL watchdog all requirements: actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0; rst_n = 1'b0;
    m_byp = 1; shp_en = 1; acp_en = 1; shp_r = 0; acp_r = 0;
    for (int i = 0; i < ND; i++) begin sh_en[i] = 1; ac_en[i] = 1; sh_r[i] = 0; ac_r[i] = 0; end
    bleft = 0; phase = 0; skip = 0; pend_wr = 0; pend_addr = 0; pend_data = 0;
    cur_tag = "R1";
    repeat (3) @(posedge clk_ref);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk_ref);
    #1;

    // R1 reset state
    check_rd(0, 16'h0001, "R1");
    check_rd(1, 0, "R1");
    check_rd(2, 16'h8000, "R1");
    check_rd(4, 0, "R1");
    for (int i = 0; i < ND; i++) check_rd(8 + i, 16'h8000, "R1");
    idle(4);

    // R8 multiplier direct write
    cur_tag = "R8";
    wr(1, 16'h0013);
    checks++;
    if (mult_val !== 5'h13) begin
      fails++;
      $display("FAIL R8 mult_val: actual=%h expected=%h", mult_val, 5'h13);
    end
    check_rd(1, 16'h0013, "R8");

    // R4 staging: outputs stay all-high until GO
    cur_tag = "R4";
    wr(8, 16'h8001);
    wr(9, 16'h8002);
    wr(10, 16'h8003);
    idle(3);
    check_rd(8, 16'h8001, "R4");
    check_rd(10, 16'h8003, "R4");

    // R5 + R2 + R6: GO, aligned restart, busy window
    cur_tag = "R5";
    wr(3, 1);
    check_rd(4, 1, "R6");
    // R7: during busy, stage a new div0 and GO again
    cur_tag = "R7";
    wr(8, 16'h8004);
    wr(3, 1);
    check_rd(8, 16'h8004, "R7");
    cur_tag = "R2";
    idle(22);
    check_rd(4, 0, "R6");

    // R3: disable divider 1 (also applies staged div0 = factor 5)
    cur_tag = "R3";
    wr(9, 16'h0002);
    wr(3, 1);
    idle(14);

    // R9: leave bypass while active post factor is 1, then post factor 2
    cur_tag = "R9";
    wr(0, 0);
    check_rd(0, 0, "R9");
    wr(2, 16'h8001);
    wr(9, 16'h8000);
    wr(3, 1);
    idle(30);

    // R10: disable post-divider outside bypass
    cur_tag = "R10";
    wr(2, 16'h0001);
    wr(3, 1);
    idle(12);

    // R9 back to bypass, re-aligned by GO
    skip = 1;
    wr(0, 1);
    skip = 0;
    cur_tag = "R9";
    wr(3, 1);
    idle(12);

    // R2 largest factor
    cur_tag = "R2";
    wr(11, 16'h801F);
    wr(8, 16'h8000);
    idle(8);
    wr(3, 1);
    idle(70);

    @(negedge clk_ref);
    #1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule